// File: doc/BRIEF.md
# Periodic Reload Down-Counter with Register Window

This peripheral sits on a simple 32-bit register bus. It holds a 32-bit control word, a 16-bit reload value and a 16-bit live count. When it is started, the count falls by one on every pulse of a tick-enable input (nominally 1 MHz). After the count reaches zero, the next pulse loads the reload value again. The counter therefore repeats with a period of reload+1 ticks.

Software writes the reload register to set the period, and that write also loads the count at once. It then sets the start bit in the control word. Bit 31 of the control word is a self-clear command. A control write with that bit set stores nothing. Instead it zeroes the control word, the reload value and the count, and stops the counter. Clearing the start bit does not stop the counter; only the clear command or hardware reset stops it. Reads are combinational and are valid in the cycle the bus requests them.

Top module: `reload_timer_top`

## Requirements
- R1: After hardware reset (active-low `rst_n`), control, reload and count all read as zero, and tick pulses leave the count at zero.
- R2: A control write (offset 0x00) whose bit 31 is clear stores the full 32-bit word, and offset 0x00 reads it back unchanged.
- R3: A reload write (offset 0x08) keeps data bits [15:0] only. Offset 0x08 reads that value zero-extended to 32 bits.
- R4: A reload write also loads the count with the same 16-bit value. Offset 0x0C shows it in the cycle after the write.
- R5: While the counter runs, each tick pulse lowers a nonzero count by one. Cycles without a tick leave the count unchanged.
- R6: While the counter runs, a tick that finds the count at zero loads the reload value. With a reload value of zero, the count stays at zero.
- R7: A control write with bit 31 set zeroes control, reload and count and stops the counter, even when bit 0 is also set. The written word is not stored.
- R8: A control write with bit 0 set and bit 31 clear starts the counter. A later control write with bit 0 clear updates the word but does not stop a running counter.
- R9: While the counter is stopped, tick pulses do not change the count.
- R10: Writes to the count offset 0x0C are ignored. Reads of any other offset in the 256-byte window, unaligned offsets included, return zero. Writes to those offsets change nothing.
- R11: `bus_rdata` is zero in any cycle that is not a read (`bus_en` low or `bus_we` high).
- R12: When a reload write and a tick arrive in the same cycle, the written value wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable pulse, one per counting step |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |

## Verification
The bench sweeps reload values from 0 to 6 over two full periods each and compares every count with reload minus (ticks mod (reload+1)). An off-by-one wrap, or a reload-zero case that underflows to 0xFFFF, shows up there at once. It reads all 256 offsets, so a decoder that ignores the low address bits or aliases 0x04 returns nonzero data and fails. Further directed cases cover:
- a clear command with the start bit also set, where a design that stores the word or keeps running fails;
- an enable-clear write, where a design that stops the counter fails;
- a reload write in the same cycle as a tick, where a design that lets the tick win fails.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_RELOAD = 2'd2,
      SEL_COUNT  = 2'd3
   } tmr_sel_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int OFS_CTRL   = 'h00,
   parameter int OFS_RELOAD = 'h08,
   parameter int OFS_COUNT  = 'h0C
) (
   input  logic [ADDR_W-1:0] addr,
   output tmr_sel_e          sel
);
   localparam int WINDOW = 1 << ADDR_W;

   if (OFS_CTRL >= WINDOW || OFS_RELOAD >= WINDOW || OFS_COUNT >= WINDOW) begin : g_bad_range
      $error("tmr_decode: offset outside window");
   end
   if ((OFS_CTRL % 4) != 0 || (OFS_RELOAD % 4) != 0 || (OFS_COUNT % 4) != 0) begin : g_bad_align
      $error("tmr_decode: offsets must be word aligned");
   end
   if (OFS_CTRL == OFS_RELOAD || OFS_CTRL == OFS_COUNT || OFS_RELOAD == OFS_COUNT) begin : g_bad_overlap
      $error("tmr_decode: offsets must differ");
   end

   // Exact match on all address bits: unaligned or other offsets hit nothing.
   always_comb begin
      if (addr == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFS_RELOAD)) sel = SEL_RELOAD;
      else if (addr == ADDR_W'(OFS_COUNT))  sel = SEL_COUNT;
      else                                  sel = SEL_NONE;
   end
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int RST_BIT = 31,
   parameter int EN_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_reload,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [CNT_W-1:0]  reload_q,
   output logic              run_q,
   output logic              soft_clr
);
   if (RST_BIT >= DATA_W || EN_BIT >= DATA_W || RST_BIT == EN_BIT) begin : g_bad_bits
      $error("tmr_ctrl_regs: invalid control bit positions");
   end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
      $error("tmr_ctrl_regs: counter width must fit the bus");
   end

   assign soft_clr = wr_ctrl & wdata[RST_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         run_q    <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= wdata;
            if (wdata[EN_BIT]) run_q <= 1'b1;
         end
         if (wr_reload) reload_q <= wdata[CNT_W-1:0];
      end
   end

   assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[RST_BIT]) |=> (ctrl_q == '0 && reload_q == '0 && !run_q));
   assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[RST_BIT] && wdata[EN_BIT]) |=> run_q);
   assert_keep_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !soft_clr) |=> run_q);
   assert_store_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[RST_BIT]) |=> ctrl_q == $past(wdata));
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_zero;
   assign at_zero = (count_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)       count_q <= '0;
      else if (load)           count_q <= load_val;
      else if (run && tick)    count_q <= at_zero ? reload_val : count_q - ONE;
   end

   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> count_q == $past(load_val));
   assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !clr && !load && count_q != '0) |=> (count_q + ONE) == $past(count_q));
   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !clr && !load && count_q == '0) |=> count_q == $past(reload_val));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && tick) && !clr && !load) |=> $stable(count_q));
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
   import tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  tmr_sel_e          sel,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] ctrl_q,
   input  logic [CNT_W-1:0]  reload_q,
   input  logic [CNT_W-1:0]  count_q,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] reload_ext, count_ext;

   if (CNT_W == DATA_W) begin : g_full
      assign reload_ext = reload_q;
      assign count_ext  = count_q;
   end else begin : g_zext
      assign reload_ext = {{(DATA_W-CNT_W){1'b0}}, reload_q};
      assign count_ext  = {{(DATA_W-CNT_W){1'b0}}, count_q};
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (sel)
            SEL_CTRL:   rdata = ctrl_q;
            SEL_RELOAD: rdata = reload_ext;
            SEL_COUNT:  rdata = count_ext;
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/reload_timer_top.sv
module reload_timer_top
   import tmr_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int RST_BIT    = 31,
   parameter int EN_BIT     = 0,
   parameter int OFS_CTRL   = 'h00,
   parameter int OFS_RELOAD = 'h08,
   parameter int OFS_COUNT  = 'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   tmr_sel_e          sel;
   logic              wr_ctrl, wr_reload, rd_en, soft_clr, run_q;
   logic [DATA_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  reload_q, count_q;

   tmr_decode #(
      .ADDR_W(ADDR_W), .OFS_CTRL(OFS_CTRL),
      .OFS_RELOAD(OFS_RELOAD), .OFS_COUNT(OFS_COUNT)
   ) i_decode (
      .addr(bus_addr), .sel(sel)
   );

   assign wr_ctrl   = bus_en &  bus_we & (sel == SEL_CTRL);
   assign wr_reload = bus_en &  bus_we & (sel == SEL_RELOAD);
   assign rd_en     = bus_en & ~bus_we;

   tmr_ctrl_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_BIT(RST_BIT), .EN_BIT(EN_BIT)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_reload(wr_reload),
      .wdata(bus_wdata), .ctrl_q(ctrl_q), .reload_q(reload_q),
      .run_q(run_q), .soft_clr(soft_clr)
   );

   tmr_down_counter #(.CNT_W(CNT_W)) i_counter (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr), .load(wr_reload),
      .load_val(bus_wdata[CNT_W-1:0]), .run(run_q), .tick(tick_i),
      .reload_val(reload_q), .count_q(count_q)
   );

   tmr_rd_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rdmux (
      .sel(sel), .rd_en(rd_en), .ctrl_q(ctrl_q), .reload_q(reload_q),
      .count_q(count_q), .rdata(bus_rdata)
   );

   assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && !bus_we) |-> bus_rdata == '0);
   assert_count_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && sel == SEL_COUNT && !tick_i) |=> $stable(count_q));
endmodule

// File: tb/test_reload_timer_top.sv
module test_reload_timer_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   reload_timer_top i_reload_timer_top (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_en(bus_en),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      expect_reg("R1 ctrl", 8'h00, 32'h0);
      expect_reg("R1 reload", 8'h08, 32'h0);
      expect_reg("R1 count", 8'h0C, 32'h0);
      ticks(3);
      expect_reg("R1 count after ticks", 8'h0C, 32'h0);

      // R2 / R3 / R4
      wr(8'h00, 32'h5A5A_0002);
      expect_reg("R2 ctrl readback", 8'h00, 32'h5A5A_0002);
      wr(8'h08, 32'hABCD_1234);
      expect_reg("R3 reload truncated", 8'h08, 32'h0000_1234);
      expect_reg("R4 count loaded", 8'h0C, 32'h0000_1234);
      ticks(2);
      expect_reg("R9 stopped count holds", 8'h0C, 32'h0000_1234);

      // R5 / R6 sweep over small reload values
      for (int r = 0; r <= 6; r++) begin
         wr(8'h00, 32'h8000_0000);
         wr(8'h08, r);
         wr(8'h00, 32'h0000_0001);
         expect_reg("R8 start keeps count", 8'h0C, r);
         for (int k = 1; k <= 2 * r + 3; k++) begin
            ticks(1);
            e = r - (k % (r + 1));
            rd(8'h0C, v);
            check(r == 0 ? "R6 zero reload" : "R5/R6 periodic count", v, e);
         end
         @(negedge clk); @(negedge clk);
         expect_reg("R5 no tick no change", 8'h0C, r - ((2 * r + 3) % (r + 1)));
      end

      // R8: clearing enable leaves counter running
      wr(8'h00, 32'h8000_0000);
      wr(8'h08, 32'd10);
      wr(8'h00, 32'h0000_0001);
      ticks(3);
      expect_reg("R5 count after 3", 8'h0C, 32'd7);
      wr(8'h00, 32'h0000_0000);
      expect_reg("R8 ctrl cleared word", 8'h00, 32'h0);
      ticks(2);
      expect_reg("R8 still running", 8'h0C, 32'd5);

      // R12: reload write and tick in the same cycle
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = 32'd3; tick_i = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; tick_i = 1'b0;
      expect_reg("R12 write wins over tick", 8'h0C, 32'd3);

      // R10: writes to count and unmapped offsets ignored
      wr(8'h00, 32'h0000_0101);
      wr(8'h0C, 32'h0000_0055);
      expect_reg("R10 count write ignored", 8'h0C, 32'd3);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h09, 32'hFFFF_FFFF);
      wr(8'h01, 32'hFFFF_FFFF);
      expect_reg("R10 ctrl untouched", 8'h00, 32'h0000_0101);
      expect_reg("R10 reload untouched", 8'h08, 32'd3);
      expect_reg("R10 count untouched", 8'h0C, 32'd3);
      for (int a = 0; a < 256; a++) begin
         rd(a[7:0], v);
         if (a == 0)       e = 32'h0000_0101;
         else if (a == 8)  e = 32'd3;
         else if (a == 12) e = 32'd3;
         else              e = 32'h0;
         check("R10 window read", v, e);
      end

      // R11: no read, no data
      @(negedge clk);
      bus_en = 1'b0; bus_addr = 8'h00; #1;
      check("R11 idle rdata", bus_rdata, 32'h0);
      bus_en = 1'b1; bus_we = 1'b1; #1;
      check("R11 write cycle rdata", bus_rdata, 32'h0);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;

      // R7: clear command with enable bit set
      wr(8'h00, 32'h8000_0001);
      expect_reg("R7 ctrl zero", 8'h00, 32'h0);
      expect_reg("R7 reload zero", 8'h08, 32'h0);
      expect_reg("R7 count zero", 8'h0C, 32'h0);
      wr(8'h08, 32'd4);
      ticks(3);
      expect_reg("R7 stopped after clear", 8'h0C, 32'd4);

      // R1: hardware reset while running
      wr(8'h00, 32'h0000_0001);
      ticks(1);
      expect_reg("R5 before reset", 8'h0C, 32'd3);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      expect_reg("R1 ctrl after reset", 8'h00, 32'h0);
      expect_reg("R1 reload after reset", 8'h08, 32'h0);
      wr(8'h08, 32'd6);
      ticks(2);
      expect_reg("R1 stopped after reset", 8'h0C, 32'd6);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule